// File: doc/BRIEF.md
# Fractional-Divider Channel Control Register

A single 32-bit control word holding the settings of four fractional clock-divider channels. Each byte of the word belongs to one channel and packs that channel's 6-bit divide fraction with a gate flag that stops the channel's clock. The intended channel frequency is the parent frequency times 18 divided by the fraction. Clock generation is left to the dividers that take the outputs.

The word sits on a simple word-addressed register bus. A write is taken on any clock edge where the write enable is high, so the enable acts as a one-cycle strobe. The 2-bit word address picks one of four write aliases. Word 0 replaces the whole register. Word 1 sets the register bits that are 1 in the write data. Word 2 clears those bits, and word 3 inverts them. The set, clear and toggle aliases let software change one channel without a read-modify-write sequence. Every channel also raises a one-cycle update strobe whenever a write changes its fraction, so the divider it drives can reload.

Top module: `fracdiv_ctrl_reg`

## Requirements
- R1: While reset is asserted and after it is released, the register reads 0x92929292: every gate flag is 1, every fraction is 18, and no update strobe is high.
- R2: A write with word address 0 replaces the register with the write data, except for the reserved bits, from the next clock edge.
- R3: A write with word address 1 sets the register bits that are 1 in the write data and leaves all other bits unchanged.
- R4: A write with word address 2 clears the register bits that are 1 in the write data and leaves all other bits unchanged.
- R5: A write with word address 3 inverts the register bits that are 1 in the write data and leaves all other bits unchanged.
- R6: Bit 6 of every byte (bits 6, 14, 22 and 30) always reads 0, whatever is written through any alias.
- R7: Read data is the current register value, the same at all four word addresses, with no wait cycle.
- R8: Channel n's fraction output equals register bits [8n+5:8n]. Channel n's gate output equals register bit 8n+7, where 1 means stopped.
- R9: Channel n's update strobe is high for exactly the one cycle after a write through any alias that changes bits [8n+5:8n]. It stays low after a write that changes only the gate flag or leaves the fraction as it was.
- R10: In a cycle with the write enable low, the register keeps its value, whatever the address and write data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Word address: 0 direct, 1 set, 2 clear, 3 toggle |
| busWe | input | 1 | Write enable; a write happens on each edge where it is high |
| busWdata | input | 32 | Write data or bit mask for the selected alias |
| busRdata | output | 32 | Current register contents |
| chFrac | output | 24 | Channel fractions, channel n at [6n+5:6n] |
| chGate | output | 4 | Channel gate flags, 1 means clock stopped |
| chUpdate | output | 4 | One-cycle per-channel fraction-change strobes |

## Verification
The hardest case to reach is a write that flips bits without changing a fraction. Examples are a toggle that touches only gate flags, a set of bits that are already 1, and a direct write of the value already held. Each of these must leave the update strobe low, while a write of nearly the same value raises it. The directed phase builds these cases on purpose, including two toggles in a row that cancel each other. A long random phase then mixes all four aliases with idle cycles, and a reference model checks every cycle against the register value it predicts.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int LANE_W   = 8;
  localparam int GATE_POS = LANE_W - 1;
  localparam int ALIAS_W  = 2;

  typedef enum logic [ALIAS_W-1:0] {
    ALIAS_DIRECT = 2'd0,
    ALIAS_SET    = 2'd1,
    ALIAS_CLR    = 2'd2,
    ALIAS_TOG    = 2'd3
  } aliasSel_e;

  typedef struct packed {
    logic wrDirect;
    logic wrSet;
    logic wrClr;
    logic wrTog;
  } wrStrobes_t;
endpackage

// File: rtl/fdc_ctrl.sv
module fdc_ctrl
  import fdc_pkg::*;
(
  input  logic [ALIAS_W-1:0] busAddr,
  input  logic               busWe,
  output wrStrobes_t         strobes
);
  aliasSel_e sel;
  assign sel = aliasSel_e'(busAddr);

  always_comb begin
    strobes = '0;
    if (busWe) begin
      unique case (sel)
        ALIAS_DIRECT: strobes.wrDirect = 1'b1;
        ALIAS_SET:    strobes.wrSet    = 1'b1;
        ALIAS_CLR:    strobes.wrClr    = 1'b1;
        ALIAS_TOG:    strobes.wrTog    = 1'b1;
        default:      strobes          = '0;
      endcase
    end
  end
endmodule

// File: rtl/fdc_datapath.sv
module fdc_datapath
  import fdc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int FRAC_W   = 6,
  parameter int RST_FRAC = 18,
  parameter int RST_GATE = 1,
  localparam int DATA_W  = NUM_CH * LANE_W
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  wrStrobes_t               strobes,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        regQ,
  output logic [NUM_CH*FRAC_W-1:0] chFrac,
  output logic [NUM_CH-1:0]        chGate,
  output logic [NUM_CH-1:0]        chUpdate
);
  localparam logic [LANE_W-1:0] LANE_MASK =
    LANE_W'((1 << GATE_POS) | ((1 << FRAC_W) - 1));
  localparam logic [LANE_W-1:0] RST_LANE =
    LANE_W'((RST_GATE << GATE_POS) | (RST_FRAC & ((1 << FRAC_W) - 1)));

  logic [DATA_W-1:0] writable;
  logic [DATA_W-1:0] rstValue;
  logic [DATA_W-1:0] nxtRaw;
  logic [DATA_W-1:0] nxtVal;
  logic [NUM_CH-1:0] fracChange;
  logic              anyWrite;

  genvar n;
  generate
    for (n = 0; n < NUM_CH; n++) begin : g_lane
      assign writable[n*LANE_W +: LANE_W] = LANE_MASK;
      assign rstValue[n*LANE_W +: LANE_W] = RST_LANE;
      assign fracChange[n] = anyWrite &&
        (nxtVal[n*LANE_W +: FRAC_W] != regQ[n*LANE_W +: FRAC_W]);
      assign chFrac[n*FRAC_W +: FRAC_W] = regQ[n*LANE_W +: FRAC_W];
      assign chGate[n] = regQ[n*LANE_W + GATE_POS];
    end
  endgenerate

  assign anyWrite = |strobes;

  always_comb begin
    nxtRaw = regQ;
    if (strobes.wrDirect) nxtRaw = wrData;
    if (strobes.wrSet)    nxtRaw = regQ | wrData;
    if (strobes.wrClr)    nxtRaw = regQ & ~wrData;
    if (strobes.wrTog)    nxtRaw = regQ ^ wrData;
  end

  assign nxtVal = nxtRaw & writable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ     <= rstValue;
      chUpdate <= '0;
    end else begin
      if (anyWrite) regQ <= nxtVal;
      chUpdate <= fracChange;
    end
  end
endmodule

// File: rtl/fracdiv_ctrl_reg.sv
module fracdiv_ctrl_reg
  import fdc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int FRAC_W   = 6,
  parameter int RST_FRAC = 18,
  parameter int RST_GATE = 1,
  localparam int DATA_W  = NUM_CH * LANE_W
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ALIAS_W-1:0]       busAddr,
  input  logic                     busWe,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  output logic [NUM_CH*FRAC_W-1:0] chFrac,
  output logic [NUM_CH-1:0]        chGate,
  output logic [NUM_CH-1:0]        chUpdate
);
  wrStrobes_t strobes;

  fdc_ctrl ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes)
  );

  fdc_datapath #(
    .NUM_CH   (NUM_CH),
    .FRAC_W   (FRAC_W),
    .RST_FRAC (RST_FRAC),
    .RST_GATE (RST_GATE)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (busWdata),
    .regQ     (busRdata),
    .chFrac   (chFrac),
    .chGate   (chGate),
    .chUpdate (chUpdate)
  );
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker
  import fdc_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int FRAC_W  = 6,
  localparam int DATA_W = NUM_CH * LANE_W
)(
  input logic                     clk,
  input logic                     rstN,
  input logic [ALIAS_W-1:0]       busAddr,
  input logic                     busWe,
  input logic [DATA_W-1:0]        busWdata,
  input logic [DATA_W-1:0]        busRdata,
  input logic [NUM_CH*FRAC_W-1:0] chFrac,
  input logic [NUM_CH-1:0]        chGate,
  input logic [NUM_CH-1:0]        chUpdate
);
  logic [DATA_W-1:0] keep;
  always_comb
    for (int i = 0; i < NUM_CH; i++)
      keep[i*LANE_W +: LANE_W] = LANE_W'((1 << GATE_POS) | ((1 << FRAC_W) - 1));

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & ~keep) == '0); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(busRdata)); // R10
  AST_DIRECT_WR: assert property (@(posedge clk) disable iff (!rstN)
    busWe && busAddr == 2'd0 |=> busRdata == ($past(busWdata) & keep)); // R2
  AST_SET_WR: assert property (@(posedge clk) disable iff (!rstN)
    busWe && busAddr == 2'd1 |=> busRdata == (($past(busRdata) | $past(busWdata)) & keep)); // R3
  AST_CLR_WR: assert property (@(posedge clk) disable iff (!rstN)
    busWe && busAddr == 2'd2 |=> busRdata == ($past(busRdata) & ~$past(busWdata))); // R4
  AST_TOG_WR: assert property (@(posedge clk) disable iff (!rstN)
    busWe && busAddr == 2'd3 |=> busRdata == (($past(busRdata) ^ $past(busWdata)) & keep)); // R5

  genvar n;
  generate
    for (n = 0; n < NUM_CH; n++) begin : g_ch
      AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
        chUpdate[n] == (chFrac[n*FRAC_W +: FRAC_W] != $past(chFrac[n*FRAC_W +: FRAC_W]))); // R9
    end
  endgenerate
endmodule

bind fracdiv_ctrl_reg fdc_checker #(.NUM_CH(NUM_CH), .FRAC_W(FRAC_W)) chk_i (.*);

// File: tb/fracdiv_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module fracdiv_ctrl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [23:0] chFrac;
  logic [3:0]  chGate;
  logic [3:0]  chUpdate;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] KEEP = 32'hBFBFBFBF;
  logic [31:0] model;
  logic [3:0]  expUpd;
  int          lastOp;

  always #2.5 clk = ~clk;

  fracdiv_ctrl_reg dut_i (.*);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      model  = 32'h92929292;
      expUpd = '0;
      lastOp = -1;
    end else begin
      logic [31:0] nxt;
      nxt = model;
      if (busWe) begin
        case (busAddr)
          2'd0: nxt = busWdata;
          2'd1: nxt = model | busWdata;
          2'd2: nxt = model & ~busWdata;
          default: nxt = model ^ busWdata;
        endcase
        nxt = nxt & KEEP;
        lastOp = int'(busAddr);
      end else lastOp = -1;
      for (int c = 0; c < 4; c++)
        expUpd[c] = busWe && (nxt[c*8 +: 6] != model[c*8 +: 6]);
      model = nxt;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      string t;
      case (lastOp)
        0: t = "R2";
        1: t = "R3";
        2: t = "R4";
        3: t = "R5";
        default: t = "R10";
      endcase
      check(busRdata == model, t, busRdata, model);
      check((busRdata & ~KEEP) == 0, "R6", busRdata, busRdata & KEEP);
      check(chUpdate == expUpd, "R9", 32'(chUpdate), 32'(expUpd));
      for (int c = 0; c < 4; c++) begin
        check(chFrac[c*6 +: 6] == model[c*8 +: 6], "R8 frac",
              32'(chFrac[c*6 +: 6]), 32'(model[c*8 +: 6]));
        check(chGate[c] == model[c*8+7], "R8 gate", 32'(chGate[c]), 32'(model[c*8+7]));
      end
    end
  end

  task automatic drive(bit we, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    #1;
    busWe = we;
    busAddr = a;
    busWdata = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    check(busRdata == 32'h92929292, "R1 in reset", busRdata, 32'h92929292);
    check(chUpdate == 0, "R1 upd in reset", 32'(chUpdate), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(busRdata == 32'h92929292, "R1", busRdata, 32'h92929292);
    check(chGate == 4'hF, "R1 gate", 32'(chGate), 32'hF);
    check(chFrac == {4{6'd18}}, "R1 frac", 32'(chFrac), 32'(24'({4{6'd18}})));
    check(chUpdate == 0, "R1 upd", 32'(chUpdate), 0);

    drive(1, 2'd0, 32'h00000000);
    drive(1, 2'd1, 32'h00000041);
    drive(1, 2'd1, 32'h00000001);
    drive(1, 2'd3, 32'h80808080);
    drive(1, 2'd3, 32'h00003F00);
    drive(1, 2'd3, 32'h00400000);
    drive(1, 2'd2, 32'h0000FF00);
    drive(1, 2'd0, 32'hFFFFFFFF);
    drive(1, 2'd0, 32'hFFFFFFFF);
    drive(1, 2'd3, 32'h01000000);
    drive(1, 2'd3, 32'h01000000);
    drive(1, 2'd2, 32'h40404040);
    drive(0, 2'd0, 32'h12345678);
    for (int a = 0; a < 4; a++) begin
      drive(0, 2'(a), 32'hDEADBEEF);
      #1;
      check(busRdata == model, "R7", busRdata, model);
    end
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 4) != 0, 2'($urandom % 4), $urandom);
    drive(0, 2'd0, 32'h0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule